// File: doc/BRIEF.md
# Memory Access Trace Capture Unit

The unit sits beside a bus that carries accesses to RAM and peripheral regions and copies selected accesses into a small FIFO. It has no way of holding the bus back: it only observes. Each observed access brings a region index, a 16-bit address, a 32-bit data word, a write flag and a master bit. Every region owns two address windows, and each window has an enable, a start address and a power-of-two size. Direction filters and master filters narrow the capture further.

In trace mode a qualifying access becomes one FIFO entry, which leaves the unit as three 32-bit words: a header, the address and the data. The header names the master, the direction and the matching region/window. In direct-data mode each entry leaves as a single raw data word. That word comes either from a software write to the data register or from a qualifying traced read. A serializer drains the unit one word at a time through a valid/pop read port. Accesses that find no room are dropped, and a sticky flag records the loss.

Top module: `mtrace_capture`

## Requirements
- R1: After reset, `rd_valid` and `ovf_flag` are 0. The internal reset is released two rising edges after `rst_n` goes high.
- R2: In trace mode (`cfg_direct`=0), a qualifying access sampled at a rising edge is output as three words. The first word shows `rd_valid`=1 in the next cycle. The words are: header = {28 zero bits, master at bit 3, write at bit 2, region at bit 1, window at bit 0}; then {16 zero bits, address}; then data. `rd_last` is 1 only on the data word, and each word advances on a cycle with `rd_pop`=1.
- R3: Window w of region r uses flat index r*2+w in the `cfg_win_*` buses. It matches when it is enabled and start <= address < start + 2^size, where size runs from 0 to 16. Only the two windows of the access's own region are considered. An access that matches no window is not captured.
- R4: When both windows of a region match, the header reports window 0.
- R5: Write accesses are captured only when `cfg_cap_wr`=1, and read accesses only when `cfg_cap_rd`=1.
- R6: Master 0 (CPU) accesses are captured only when `cfg_cap_cpu`=1, and master 1 (DMA) accesses only when `cfg_cap_dma`=1.
- R7: In direct-data mode, a data-register write (`dreg_wr`) and a qualifying read (same window, master and `cfg_cap_rd` rules) each push one entry. That entry is output as a single word equal to the data, with `rd_last`=1. Bus writes are never captured in this mode.
- R8: In trace mode, `dreg_wr` has no effect.
- R9: The FIFO holds `FIFO_DEPTH` entries (default 4) and outputs them in arrival order. A capture that finds the FIFO full at the edge is dropped, and `ovf_flag` reads 1 from the next cycle.
- R10: `ovf_flag` stays set until a cycle with `ovf_clr`=1 clears it. When a new drop coincides with `ovf_clr`, the flag stays set.
- R11: In direct-data mode, if `dreg_wr` and a qualifying read arrive in the same cycle, the register word is kept, the read is dropped and `ovf_flag` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_direct | input | 1 | 1 = direct-data mode, 0 = trace mode |
| cfg_cap_wr | input | 1 | Capture write accesses |
| cfg_cap_rd | input | 1 | Capture read accesses |
| cfg_cap_cpu | input | 1 | Capture master 0 accesses |
| cfg_cap_dma | input | 1 | Capture master 1 accesses |
| cfg_win_en | input | 4 | Enable per window, flat index r*2+w |
| cfg_win_start | input | 64 | Start addresses, 16 bits per window |
| cfg_win_size | input | 20 | log2 window size, 5 bits per window |
| bus_valid | input | 1 | An access is present on the bus this cycle |
| bus_region | input | 1 | Region index of the access |
| bus_addr | input | 16 | Access address |
| bus_data | input | 32 | Access data |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_master | input | 1 | 0 = CPU, 1 = DMA |
| dreg_wr | input | 1 | Software write to the direct data register |
| dreg_data | input | 32 | Data-register value |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| ovf_flag | output | 1 | Sticky drop indicator |
| rd_valid | output | 1 | An output word is available |
| rd_data | output | 32 | Output word |
| rd_last | output | 1 | Current word ends its packet |
| rd_pop | input | 1 | Consume the current word |

## Verification
An access or data-register write driven in cycle N is captured at the edge that closes N. Its first word, and any change of `ovf_flag`, therefore appear in cycle N+1, so the bench checks both at the falling edge that follows the capture edge. Each later word of a packet appears one cycle after the pop that consumed the previous word, and the bench samples again at the next falling edge. An access that must be ignored is checked by confirming, at that same point, that `rd_valid` is still low before any other stimulus is applied.

// File: rtl/mtrace_pkg.sv
package mtrace_pkg;
  localparam int unsigned MT_AW   = 16;
  localparam int unsigned MT_DW   = 32;
  localparam int unsigned MT_NREG = 2;
  localparam int unsigned MT_WPR  = 2;
  localparam int unsigned MT_NWIN = MT_NREG * MT_WPR;
  localparam int unsigned MT_RGW  = (MT_NREG > 1) ? $clog2(MT_NREG) : 1;
  localparam int unsigned MT_WSW  = (MT_WPR > 1) ? $clog2(MT_WPR) : 1;
  localparam int unsigned MT_IDXW = MT_RGW + MT_WSW;
  localparam int unsigned MT_HDRW = 2 + MT_IDXW;
  localparam int unsigned MT_SZW  = $clog2(MT_AW + 1);

  // One stored capture: mode tag, header, address, data
  typedef struct packed {
    logic               direct;
    logic [MT_HDRW-1:0] hdr;
    logic [MT_AW-1:0]   addr;
    logic [MT_DW-1:0]   data;
  } mt_entry_t;
endpackage

// File: rtl/mtrace_win_match.sv
module mtrace_win_match
  import mtrace_pkg::*;
#(
  parameter int unsigned AW  = MT_AW,
  parameter int unsigned SZW = MT_SZW
) (
  input  logic           en,
  input  logic [AW-1:0]  addr,
  input  logic [AW-1:0]  start,
  input  logic [SZW-1:0] size_log2,
  output logic           hit
);
  logic [AW:0]   offs;
  logic [AW-1:0] hi_mask;

  // offset from start must be non-negative and below 2^size
  always_comb begin
    offs = {1'b0, addr} - {1'b0, start};
    for (int i = 0; i < int'(AW); i++) begin
      hi_mask[i] = (i >= int'(size_log2));
    end
    hit = en && !offs[AW] && ((offs[AW-1:0] & hi_mask) == '0);
  end
endmodule

// File: rtl/mtrace_qualify.sv
module mtrace_qualify
  import mtrace_pkg::*;
#(
  parameter int unsigned AW   = MT_AW,
  parameter int unsigned SZW  = MT_SZW,
  parameter int unsigned NREG = MT_NREG,
  parameter int unsigned WPR  = MT_WPR,
  parameter int unsigned RGW  = MT_RGW,
  parameter int unsigned WSW  = MT_WSW,
  localparam int unsigned NWIN = NREG * WPR
) (
  input  logic                bus_valid,
  input  logic [RGW-1:0]      bus_region,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_write,
  input  logic                bus_master,
  input  logic                cap_wr,
  input  logic                cap_rd,
  input  logic                cap_cpu,
  input  logic                cap_dma,
  input  logic [NWIN-1:0]     win_en,
  input  logic [NWIN*AW-1:0]  win_start,
  input  logic [NWIN*SZW-1:0] win_size,
  output logic                hit,
  output logic [RGW+WSW-1:0]  idx
);
  logic [NWIN-1:0] win_hit;
  logic [WPR-1:0]  reg_hits;
  logic [WSW-1:0]  wsel;
  logic            found;
  logic            dir_ok;
  logic            mst_ok;

  for (genvar j = 0; j < NWIN; j++) begin : g_win
    mtrace_win_match #(.AW(AW), .SZW(SZW)) u_match (
      .en        (win_en[j]),
      .addr      (bus_addr),
      .start     (win_start[j*AW +: AW]),
      .size_log2 (win_size[j*SZW +: SZW]),
      .hit       (win_hit[j])
    );
  end

  always_comb begin
    reg_hits = '0;
    for (int r = 0; r < int'(NREG); r++) begin
      if (bus_region == RGW'(r)) begin
        for (int w = 0; w < int'(WPR); w++) begin
          reg_hits[w] = win_hit[r*WPR + w];
        end
      end
    end
    // descending scan so the lowest window index wins
    found = 1'b0;
    wsel  = '0;
    for (int w = int'(WPR) - 1; w >= 0; w--) begin
      if (reg_hits[w]) begin
        found = 1'b1;
        wsel  = WSW'(w);
      end
    end
    dir_ok = bus_write  ? cap_wr  : cap_rd;
    mst_ok = bus_master ? cap_dma : cap_cpu;
    hit    = bus_valid && dir_ok && mst_ok && found;
    idx    = {bus_region, wsel};
  end
endmodule

// File: rtl/mtrace_fifo.sv
module mtrace_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned EW    = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [EW-1:0] wdata,
  input  logic          pop,
  output logic [EW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, wptr_nxt;
  logic [PW-1:0] rptr, rptr_nxt;
  logic [CW-1:0] count_nxt;
  logic          do_push, do_pop;

  always_comb begin
    full     = (count == CW'(DEPTH));
    empty    = (count == '0);
    do_push  = push && !full;
    do_pop   = pop && !empty;
    wptr_nxt = wptr;
    rptr_nxt = rptr;
    if (do_push) wptr_nxt = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
    if (do_pop)  rptr_nxt = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    count_nxt = count;
    if (do_push && !do_pop)      count_nxt = count + 1'b1;
    else if (do_pop && !do_push) count_nxt = count - 1'b1;
    rdata = mem[rptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_nxt;
      rptr  <= rptr_nxt;
      count <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end
endmodule

// File: rtl/mtrace_unpack.sv
module mtrace_unpack
  import mtrace_pkg::*;
#(
  parameter int unsigned DW   = MT_DW,
  parameter int unsigned AW   = MT_AW,
  parameter int unsigned HDRW = MT_HDRW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  mt_entry_t       head,
  input  logic            avail,
  input  logic            rd_pop,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic            rd_last,
  output logic            fifo_pop
);
  typedef enum logic [1:0] {W_HDR = 2'd0, W_ADDR = 2'd1, W_DATA = 2'd2} word_e;

  word_e wsel, wsel_nxt;
  logic  adv;

  always_comb begin
    rd_valid = avail;
    unique case (wsel)
      W_HDR:   rd_data = {{(DW-HDRW){1'b0}}, head.hdr};
      W_ADDR:  rd_data = {{(DW-AW){1'b0}}, head.addr};
      default: rd_data = head.data;
    endcase
    if (head.direct) rd_data = head.data;
    rd_last  = head.direct || (wsel == W_DATA);
    adv      = rd_valid && rd_pop;
    fifo_pop = adv && rd_last;
    wsel_nxt = wsel;
    if (adv) begin
      if (rd_last)           wsel_nxt = W_HDR;
      else if (wsel == W_HDR) wsel_nxt = W_ADDR;
      else                   wsel_nxt = W_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wsel <= W_HDR;
    else        wsel <= wsel_nxt;
  end
endmodule

// File: rtl/mtrace_capture.sv
module mtrace_capture
  import mtrace_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_direct,
  input  logic                    cfg_cap_wr,
  input  logic                    cfg_cap_rd,
  input  logic                    cfg_cap_cpu,
  input  logic                    cfg_cap_dma,
  input  logic [MT_NWIN-1:0]      cfg_win_en,
  input  logic [MT_NWIN*MT_AW-1:0]  cfg_win_start,
  input  logic [MT_NWIN*MT_SZW-1:0] cfg_win_size,
  input  logic                    bus_valid,
  input  logic [MT_RGW-1:0]       bus_region,
  input  logic [MT_AW-1:0]        bus_addr,
  input  logic [MT_DW-1:0]        bus_data,
  input  logic                    bus_write,
  input  logic                    bus_master,
  input  logic                    dreg_wr,
  input  logic [MT_DW-1:0]        dreg_data,
  input  logic                    ovf_clr,
  output logic                    ovf_flag,
  output logic                    rd_valid,
  output logic [MT_DW-1:0]        rd_data,
  output logic                    rd_last,
  input  logic                    rd_pop
);
  localparam int unsigned EW   = $bits(mt_entry_t);
  localparam int unsigned CNTW = $clog2(FIFO_DEPTH + 1);

  logic [1:0]          rst_pipe;
  logic                rst_s;
  logic                q_hit;
  logic [MT_IDXW-1:0]  q_idx;
  logic                want, collide, push, drop;
  logic                ovf_nxt;
  mt_entry_t           ent, head;
  logic [EW-1:0]       head_raw;
  logic [CNTW-1:0]     fifo_cnt;
  logic                fifo_full, fifo_empty, fifo_pop;
  logic                head_direct;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  mtrace_qualify u_qual (
    .bus_valid  (bus_valid),
    .bus_region (bus_region),
    .bus_addr   (bus_addr),
    .bus_write  (bus_write),
    .bus_master (bus_master),
    .cap_wr     (cfg_cap_wr),
    .cap_rd     (cfg_cap_rd),
    .cap_cpu    (cfg_cap_cpu),
    .cap_dma    (cfg_cap_dma),
    .win_en     (cfg_win_en),
    .win_start  (cfg_win_start),
    .win_size   (cfg_win_size),
    .hit        (q_hit),
    .idx        (q_idx)
  );

  always_comb begin
    if (cfg_direct) begin
      want    = dreg_wr || (q_hit && !bus_write);
      collide = dreg_wr && q_hit && !bus_write;
    end else begin
      want    = q_hit;
      collide = 1'b0;
    end
    push       = want && !fifo_full;
    drop       = (want && fifo_full) || collide;
    ent.direct = cfg_direct;
    ent.hdr    = {bus_master, bus_write, q_idx};
    ent.addr   = bus_addr;
    ent.data   = (cfg_direct && dreg_wr) ? dreg_data : bus_data;
    if (drop)         ovf_nxt = 1'b1;
    else if (ovf_clr) ovf_nxt = 1'b0;
    else              ovf_nxt = ovf_flag;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) ovf_flag <= 1'b0;
    else        ovf_flag <= ovf_nxt;
  end

  mtrace_fifo #(.DEPTH(FIFO_DEPTH), .EW(EW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_s),
    .push  (push),
    .wdata (ent),
    .pop   (fifo_pop),
    .rdata (head_raw),
    .count (fifo_cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  assign head        = mt_entry_t'(head_raw);
  assign head_direct = head.direct;

  mtrace_unpack u_unpack (
    .clk      (clk),
    .rst_n    (rst_s),
    .head     (head),
    .avail    (!fifo_empty),
    .rd_pop   (rd_pop),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_last  (rd_last),
    .fifo_pop (fifo_pop)
  );
endmodule

// File: rtl/mtrace_capture_chk.sv
module mtrace_capture_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input logic          clk,
  input logic          rst_s,
  input logic          cfg_direct,
  input logic          cfg_cap_wr,
  input logic          bus_valid,
  input logic          bus_write,
  input logic          dreg_wr,
  input logic          ovf_clr,
  input logic          ovf_flag,
  input logic          rd_valid,
  input logic          rd_last,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_cnt,
  input logic          head_direct
);
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_s)
    fifo_cnt <= CW'(DEPTH));

  a_r9_no_grow_full: assert property (@(posedge clk) disable iff (!rst_s)
    fifo_full |=> fifo_cnt <= $past(fifo_cnt));

  a_r9_ovf_cause: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(ovf_flag) |-> $past(fifo_full || (cfg_direct && dreg_wr && bus_valid)));

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_s)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r7_direct_single: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_valid && head_direct) |-> rd_last);

  a_r5_wr_filtered: assert property (@(posedge clk) disable iff (!rst_s)
    (!cfg_direct && bus_valid && bus_write && !cfg_cap_wr) |=> fifo_cnt <= $past(fifo_cnt));

  a_r1_valid_needs_data: assert property (@(posedge clk) disable iff (!rst_s)
    rd_valid |-> fifo_cnt != '0);
endmodule

bind mtrace_capture mtrace_capture_chk #(.DEPTH(FIFO_DEPTH), .CW(CNTW)) u_chk (
  .clk         (clk),
  .rst_s       (rst_s),
  .cfg_direct  (cfg_direct),
  .cfg_cap_wr  (cfg_cap_wr),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .dreg_wr     (dreg_wr),
  .ovf_clr     (ovf_clr),
  .ovf_flag    (ovf_flag),
  .rd_valid    (rd_valid),
  .rd_last     (rd_last),
  .fifo_full   (fifo_full),
  .fifo_cnt    (fifo_cnt),
  .head_direct (head_direct)
);

// File: tb/mtrace_capture_tb.sv
module mtrace_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_direct, cfg_cap_wr, cfg_cap_rd, cfg_cap_cpu, cfg_cap_dma;
  logic [3:0]  cfg_win_en;
  logic [63:0] cfg_win_start;
  logic [19:0] cfg_win_size;
  logic        bus_valid, bus_write, bus_master;
  logic [0:0]  bus_region;
  logic [15:0] bus_addr;
  logic [31:0] bus_data;
  logic        dreg_wr;
  logic [31:0] dreg_data;
  logic        ovf_clr, ovf_flag, rd_valid, rd_last, rd_pop;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;
  int st [4];
  int sz [4];
  bit en [4];

  always #4ns clk = ~clk;

  mtrace_capture dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_direct(cfg_direct), .cfg_cap_wr(cfg_cap_wr), .cfg_cap_rd(cfg_cap_rd),
    .cfg_cap_cpu(cfg_cap_cpu), .cfg_cap_dma(cfg_cap_dma),
    .cfg_win_en(cfg_win_en), .cfg_win_start(cfg_win_start), .cfg_win_size(cfg_win_size),
    .bus_valid(bus_valid), .bus_region(bus_region), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_write(bus_write), .bus_master(bus_master),
    .dreg_wr(dreg_wr), .dreg_data(dreg_data), .ovf_clr(ovf_clr),
    .ovf_flag(ovf_flag), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .rd_pop(rd_pop)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_cfg();
    for (int j = 0; j < 4; j++) begin
      cfg_win_en[j]            = en[j];
      cfg_win_start[j*16 +: 16] = 16'(st[j]);
      cfg_win_size[j*5 +: 5]    = 5'(sz[j]);
    end
  endtask

  task automatic access(input int rg, input int a, input logic [31:0] d,
                        input logic wr, input logic mst);
    @(negedge clk);
    bus_region = 1'(rg); bus_addr = 16'(a); bus_data = d;
    bus_write = wr; bus_master = mst; bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic dreg_write(input logic [31:0] d);
    @(negedge clk);
    dreg_data = d; dreg_wr = 1'b1;
    @(negedge clk);
    dreg_wr = 1'b0;
  endtask

  // check the current word at a falling edge, then consume it
  task automatic take_word(input string req, input logic [31:0] d, input logic last);
    check({req, " valid"}, {31'b0, rd_valid}, 32'd1);
    check({req, " data"}, rd_data, d);
    check({req, " last"}, {31'b0, rd_last}, {31'b0, last});
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  function automatic int win_of(input int rg, input int a);
    for (int w = 0; w < 2; w++) begin
      int j = rg*2 + w;
      if (en[j] && a >= st[j] && a < st[j] + (1 << sz[j])) return w;
    end
    return -1;
  endfunction

  initial begin : main
    int addrs [12] = '{16'h0FFF, 16'h1000, 16'h1007, 16'h1008, 16'h100F, 16'h1010,
                       16'h1107, 16'h1108, 16'hFFEF, 16'hFFF0, 16'hFFFF, 16'h0000};
    rst_n = 1'b0;
    cfg_direct = 0; cfg_cap_wr = 1; cfg_cap_rd = 1; cfg_cap_cpu = 1; cfg_cap_dma = 1;
    bus_valid = 0; bus_region = 0; bus_addr = 0; bus_data = 0; bus_write = 0; bus_master = 0;
    dreg_wr = 0; dreg_data = 0; ovf_clr = 0; rd_pop = 0;
    st[0] = 16'h1000; sz[0] = 4;  en[0] = 1;
    st[1] = 16'h1008; sz[1] = 8;  en[1] = 1;
    st[2] = 16'hFFF0; sz[2] = 4;  en[2] = 1;
    st[3] = 16'h0000; sz[3] = 16; en[3] = 0;
    apply_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rd_valid after reset", {31'b0, rd_valid}, 32'd0);
    check("R1 ovf after reset", {31'b0, ovf_flag}, 32'd0);

    // sweep: windows, boundaries, direction and master filters
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) begin
        sz[0] = 0; en[3] = 1;
        apply_cfg();
      end
      for (int rg = 0; rg < 2; rg++)
        for (int ai = 0; ai < 12; ai++)
          for (int f = 0; f < 16; f++)
            for (int k = 0; k < 4; k++) begin
              logic wr, mst, dok, mok;
              logic [31:0] d;
              int w;
              wr = k[0]; mst = k[1];
              cfg_cap_wr = f[0]; cfg_cap_rd = f[1]; cfg_cap_cpu = f[2]; cfg_cap_dma = f[3];
              d = {16'(addrs[ai]), 4'(f), 4'(k), 7'(rg*12 + ai), 1'(pass)};
              access(rg, addrs[ai], d, wr, mst);
              w   = win_of(rg, addrs[ai]);
              dok = wr ? f[0] : f[1];
              mok = mst ? f[3] : f[2];
              if (w >= 0 && dok && mok) begin
                take_word((w == 0 && win_of(rg, addrs[ai]) == 0 && en[rg*2+1]) ? "R4 hdr" : "R2 hdr",
                          {28'b0, mst, wr, 1'(rg), 1'(w)}, 1'b0);
                take_word("R2 addr", {16'b0, 16'(addrs[ai])}, 1'b0);
                take_word("R2 dat", d, 1'b1);
                check("R2 packet end", {31'b0, rd_valid}, 32'd0);
              end else if (w < 0) begin
                check("R3 no window", {31'b0, rd_valid}, 32'd0);
              end else if (!dok) begin
                check("R5 direction filter", {31'b0, rd_valid}, 32'd0);
              end else begin
                check("R6 master filter", {31'b0, rd_valid}, 32'd0);
              end
            end
    end
    check("R9 no overflow in sweep", {31'b0, ovf_flag}, 32'd0);

    // overflow in trace mode
    cfg_cap_wr = 1; cfg_cap_rd = 1; cfg_cap_cpu = 1; cfg_cap_dma = 1;
    for (int n = 0; n < 4; n++) access(1, 16'h2000 + n, 32'hD000_0000 + n, 1'b1, 1'b0);
    check("R9 full no overflow", {31'b0, ovf_flag}, 32'd0);
    access(1, 16'h2004, 32'hD000_0004, 1'b1, 1'b0);
    check("R9 overflow set", {31'b0, ovf_flag}, 32'd1);
    for (int n = 0; n < 4; n++) begin
      take_word("R9 order hdr", {28'b0, 1'b0, 1'b1, 1'b1, 1'b1}, 1'b0);
      take_word("R9 order addr", 32'h2000 + n, 1'b0);
      take_word("R9 order data", 32'hD000_0000 + n, 1'b1);
    end
    check("R9 fifth dropped", {31'b0, rd_valid}, 32'd0);
    check("R10 sticky", {31'b0, ovf_flag}, 32'd1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check("R10 cleared", {31'b0, ovf_flag}, 32'd0);

    // trace mode ignores the data register
    dreg_write(32'h1234_5678);
    check("R8 dreg ignored", {31'b0, rd_valid}, 32'd0);

    // direct-data mode
    cfg_direct = 1;
    dreg_write(32'hA5A5_0001);
    take_word("R7 dreg word", 32'hA5A5_0001, 1'b1);
    check("R7 dreg single", {31'b0, rd_valid}, 32'd0);
    access(0, 16'h1000, 32'hBEEF_0002, 1'b0, 1'b1);
    take_word("R7 traced read", 32'hBEEF_0002, 1'b1);
    check("R7 read single", {31'b0, rd_valid}, 32'd0);
    access(0, 16'h1000, 32'hBEEF_0003, 1'b1, 1'b0);
    check("R7 write ignored", {31'b0, rd_valid}, 32'd0);
    access(0, 16'h5000, 32'hBEEF_0004, 1'b0, 1'b0);
    check("R7 read outside window", {31'b0, rd_valid}, 32'd0);
    check("R7 no overflow", {31'b0, ovf_flag}, 32'd0);

    // collision with a simultaneous clear
    @(negedge clk);
    bus_region = 0; bus_addr = 16'h1000; bus_data = 32'hBEEF_0005;
    bus_write = 0; bus_master = 0; bus_valid = 1;
    dreg_data = 32'hA5A5_0006; dreg_wr = 1; ovf_clr = 1;
    @(negedge clk);
    bus_valid = 0; dreg_wr = 0; ovf_clr = 0;
    check("R11 collision overflow", {31'b0, ovf_flag}, 32'd1);
    check("R10 set wins over clear", {31'b0, ovf_flag}, 32'd1);
    take_word("R11 register kept", 32'hA5A5_0006, 1'b1);
    check("R11 read dropped", {31'b0, rd_valid}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule